// File: doc/BRIEF.md
# Carry-Lookahead Adder/Subtractor with Condition Flags

This block is a purely combinational N-bit integer adder/subtractor. It is built for an execution datapath that needs a short carry path. The operands are cut into 4-bit slices. Each slice resolves its own internal carries in parallel and reports a slice-level generate and propagate. A second-level lookahead unit turns those slice signals into the carry entering every slice, using the same sum-of-products form as inside a slice. The carry path is therefore two shallow AND-OR levels rather than one cell per bit.

A subtract control selects operand B or its bitwise inverse and forces the initial carry to one, which adds the two's complement of B. Next to the result the block reports four condition flags: negative, zero, carry and signed overflow. The carry flag is the raw carry out of the top bit in both modes, so after a subtraction a one means that no borrow occurred. Overflow is the XOR of the carry into the top bit and the carry out of it. The width is a parameter and must be a multiple of 4. The default is 16 bits, which gives four slices.

Top module: `addsub_cla`

## Requirements
- R1: With subMode=0, sumOut equals (opA + opB + carryIn) modulo 2^WIDTH, with every operand read as unsigned.
- R2: With subMode=1, sumOut equals (opA - opB) modulo 2^WIDTH, and carryIn has no effect on any output.
- R3: negFlag equals bit WIDTH-1 of sumOut.
- R4: zeroFlag is 1 exactly when all WIDTH bits of sumOut are 0.
- R5: carryFlag is bit WIDTH of the unsigned sum opA + B' + c0. Here B' is opB when subMode=0 and ~opB when subMode=1. c0 is carryIn when subMode=0 and 1 when subMode=1. After a subtraction, carryFlag=1 means opA >= opB unsigned, so no borrow occurred.
- R6: ovfFlag is 1 exactly when the true signed result does not fit in WIDTH bits. For subMode=0 the true result is opA + opB + carryIn; for subMode=1 it is opA - opB, with the operands read as two's complement.
- R7: The carry into each 4-bit slice equals the carry out of the unsigned sum of all lower bits plus c0. A carry therefore crosses every slice boundary, for example all-ones + 1 gives zero with carryFlag=1.
- R8: WIDTH is a parameter that is a multiple of 4, with a default of 16. An 8-bit build behaves by R1 to R7 at its own width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand (subtrahend when subtracting) |
| subMode | input | 1 | 1 = subtract opB, 0 = add |
| carryIn | input | 1 | Carry into bit 0 when adding; ignored when subtracting |
| sumOut | output | WIDTH | Result |
| negFlag | output | 1 | Result sign bit |
| zeroFlag | output | 1 | Result is all zeros |
| carryFlag | output | 1 | Raw carry out of the top bit |
| ovfFlag | output | 1 | Signed overflow |

## Verification
The embedded assertions check several properties whenever the inputs settle:
- Each slice's internal carry agrees with its generate/propagate summary.
- Every inter-slice carry matches plain arithmetic on the lower bits.
- The overflow flag follows the operand-sign rule.
- The subtraction result and no-borrow flag are consistent with the operands.

Only the bench's scenarios can show some behaviours:
- That carryIn is truly ignored in subtract mode.
- That the flags are right across the full cross-product of operands: an exhaustive 8-bit sweep, plus a 16-bit build driven with zero, one, the extreme signed values, -1 and alternating patterns.

// File: rtl/addsub_cla_pkg.sv
package addsub_cla_pkg;

  localparam int MAX_TERMS = 32;

  // strobes from control to datapath
  typedef struct packed {
    logic invertB;
    logic forceCarry;
  } ctrlStrobes_t;

  // carry out of an n-term lookahead chain: OR over j of g[j]&p[j+1..n-1], plus c0&p[0..n-1]
  function automatic logic lookaheadCarry(input logic [MAX_TERMS-1:0] gen,
                                          input logic [MAX_TERMS-1:0] prop,
                                          input logic c0,
                                          input int n);
    logic acc;
    logic prod;
    acc = 1'b0;
    for (int j = 0; j < MAX_TERMS; j++) begin
      if (j < n) begin
        prod = gen[j];
        for (int k = j + 1; k < MAX_TERMS; k++) begin
          if (k < n) prod = prod & prop[k];
        end
        acc = acc | prod;
      end
    end
    prod = c0;
    for (int k = 0; k < MAX_TERMS; k++) begin
      if (k < n) prod = prod & prop[k];
    end
    return acc | prod;
  endfunction

endpackage

// File: rtl/cla_group.sv
module cla_group
  import addsub_cla_pkg::*;
#(
  parameter int GROUP_W = 4
) (
  input  logic [GROUP_W-1:0] a,
  input  logic [GROUP_W-1:0] b,
  input  logic               cIn,
  output logic [GROUP_W-1:0] sum,
  output logic               topCarryIn,
  output logic               grpGen,
  output logic               grpProp
);

  localparam int PAD = MAX_TERMS - GROUP_W;

  logic [GROUP_W-1:0] bitGen;
  logic [GROUP_W-1:0] bitProp;
  logic [GROUP_W:0]   bitCarry;

  assign bitGen  = a & b;
  assign bitProp = a | b;

  // every carry inside the slice in parallel
  genvar i;
  generate
    for (i = 0; i <= GROUP_W; i++) begin : g_carry
      if (i == 0) begin : g_first
        assign bitCarry[i] = cIn;
      end else begin : g_rest
        assign bitCarry[i] = lookaheadCarry({{PAD{1'b0}}, bitGen},
                                            {{PAD{1'b0}}, bitProp}, cIn, i);
      end
    end
  endgenerate

  assign sum        = a ^ b ^ bitCarry[GROUP_W-1:0];
  assign topCarryIn = bitCarry[GROUP_W-1];
  assign grpGen     = lookaheadCarry({{PAD{1'b0}}, bitGen},
                                     {{PAD{1'b0}}, bitProp}, 1'b0, GROUP_W);
  assign grpProp    = &bitProp;

  // R7: slice carry-out agrees with the slice generate/propagate summary
  always_comb begin
    if (!$isunknown({a, b, cIn})) begin
      a_r7_group_summary: assert (bitCarry[GROUP_W] == (grpGen | (grpProp & cIn)))
        else $error("slice carry disagrees with G/P summary");
    end
  end

endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead
  import addsub_cla_pkg::*;
#(
  parameter int NUM_GROUPS = 4
) (
  input  logic [NUM_GROUPS-1:0] grpGen,
  input  logic [NUM_GROUPS-1:0] grpProp,
  input  logic                  c0,
  output logic [NUM_GROUPS:0]   groupCarry
);

  localparam int PAD = MAX_TERMS - NUM_GROUPS;

  genvar k;
  generate
    for (k = 0; k <= NUM_GROUPS; k++) begin : g_level2
      if (k == 0) begin : g_first
        assign groupCarry[k] = c0;
      end else begin : g_rest
        assign groupCarry[k] = lookaheadCarry({{PAD{1'b0}}, grpGen},
                                              {{PAD{1'b0}}, grpProp}, c0, k);
      end
    end
  endgenerate

endmodule

// File: rtl/addsub_datapath.sv
module addsub_datapath
  import addsub_cla_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int GROUP_W = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  ctrlStrobes_t     strobes,
  output logic [WIDTH-1:0] sumOut,
  output logic             negFlag,
  output logic             zeroFlag,
  output logic             carryFlag,
  output logic             ovfFlag
);

  localparam int NUM_GROUPS = WIDTH / GROUP_W;

  logic [WIDTH-1:0]      bEff;
  logic                  c0;
  logic [NUM_GROUPS-1:0] grpGen;
  logic [NUM_GROUPS-1:0] grpProp;
  logic [NUM_GROUPS-1:0] topCarry;
  logic [NUM_GROUPS:0]   groupCarry;

  assign bEff = strobes.invertB ? ~opB : opB;
  assign c0   = strobes.forceCarry | carryIn;

  genvar k;
  generate
    for (k = 0; k < NUM_GROUPS; k++) begin : g_slice
      cla_group #(.GROUP_W(GROUP_W)) u_group (
        .a          (opA[k*GROUP_W +: GROUP_W]),
        .b          (bEff[k*GROUP_W +: GROUP_W]),
        .cIn        (groupCarry[k]),
        .sum        (sumOut[k*GROUP_W +: GROUP_W]),
        .topCarryIn (topCarry[k]),
        .grpGen     (grpGen[k]),
        .grpProp    (grpProp[k])
      );

      // R7: carry into this slice matches arithmetic on the lower bits
      if (k > 0) begin : g_chk
        logic [k*GROUP_W:0] lowSum;
        assign lowSum = {1'b0, opA[k*GROUP_W-1:0]} + {1'b0, bEff[k*GROUP_W-1:0]}
                        + {{(k*GROUP_W){1'b0}}, c0};
        always_comb begin
          if (!$isunknown({opA, bEff, c0})) begin
            a_r7_inter_group: assert (groupCarry[k] == lowSum[k*GROUP_W])
              else $error("inter-slice carry wrong at slice %0d", k);
          end
        end
      end
    end
  endgenerate

  cla_lookahead #(.NUM_GROUPS(NUM_GROUPS)) u_lookahead (
    .grpGen     (grpGen),
    .grpProp    (grpProp),
    .c0         (c0),
    .groupCarry (groupCarry)
  );

  // condition flags
  assign negFlag   = sumOut[WIDTH-1];
  assign zeroFlag  = ~|sumOut;
  assign carryFlag = groupCarry[NUM_GROUPS];
  assign ovfFlag   = topCarry[NUM_GROUPS-1] ^ groupCarry[NUM_GROUPS];

  // R6: overflow only when the effective operands share a sign that the result lacks
  always_comb begin
    if (!$isunknown({opA, bEff, c0})) begin
      a_r6_overflow_sign: assert (ovfFlag ==
          ((opA[WIDTH-1] == bEff[WIDTH-1]) && (sumOut[WIDTH-1] != opA[WIDTH-1])))
        else $error("overflow flag disagrees with sign rule");
    end
  end

endmodule

// File: rtl/addsub_ctrl.sv
module addsub_ctrl
  import addsub_cla_pkg::*;
(
  input  logic         subMode,
  output ctrlStrobes_t strobes
);

  always_comb begin
    strobes            = '0;
    strobes.invertB    = subMode;
    strobes.forceCarry = subMode;
  end

endmodule

// File: rtl/addsub_cla.sv
module addsub_cla
  import addsub_cla_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int GROUP_W = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             subMode,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             negFlag,
  output logic             zeroFlag,
  output logic             carryFlag,
  output logic             ovfFlag
);

  ctrlStrobes_t strobes;

  initial begin
    a_r8_width_multiple: assert (WIDTH % GROUP_W == 0 && WIDTH / GROUP_W <= MAX_TERMS)
      else $error("WIDTH must be a multiple of the slice width");
  end

  addsub_ctrl u_ctrl (
    .subMode (subMode),
    .strobes (strobes)
  );

  addsub_datapath #(.WIDTH(WIDTH), .GROUP_W(GROUP_W)) u_datapath (
    .opA       (opA),
    .opB       (opB),
    .carryIn   (carryIn),
    .strobes   (strobes),
    .sumOut    (sumOut),
    .negFlag   (negFlag),
    .zeroFlag  (zeroFlag),
    .carryFlag (carryFlag),
    .ovfFlag   (ovfFlag)
  );

  always_comb begin
    if (!$isunknown({opA, opB, subMode, carryIn})) begin
      // R2: subtraction result
      if (subMode) begin
        a_r2_difference: assert (sumOut == WIDTH'(opA - opB))
          else $error("difference wrong");
        // R5: carry after subtract means no borrow
        a_r5_no_borrow: assert (carryFlag == (opA >= opB))
          else $error("borrow convention broken");
      end
      // R4: zero flag tracks an all-zero result
      a_r4_zero: assert (zeroFlag == (sumOut == '0))
        else $error("zero flag wrong");
    end
  end

endmodule

// File: tb/addsub_cla_test.sv
module addsub_cla_test;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // 8-bit build for exhaustive sweep
  logic [7:0] a8, b8, s8;
  logic sub8, cin8, n8, z8, c8, v8;
  addsub_cla #(.WIDTH(8)) uut (
    .opA(a8), .opB(b8), .subMode(sub8), .carryIn(cin8),
    .sumOut(s8), .negFlag(n8), .zeroFlag(z8), .carryFlag(c8), .ovfFlag(v8));

  // default 16-bit build for corners
  logic [15:0] a16, b16, s16;
  logic sub16, cin16, n16, z16, c16, v16;
  addsub_cla uut16 (
    .opA(a16), .opB(b16), .subMode(sub16), .carryIn(cin16),
    .sumOut(s16), .negFlag(n16), .zeroFlag(z16), .carryFlag(c16), .ovfFlag(v16));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected results computed arithmetically
  task automatic expect_vals(input int w, input longint a, input longint b,
                             input bit sub, input bit cin,
                             output longint sum, output bit n, output bit z,
                             output bit c, output bit v);
    longint mask, uns, sa, sb, exact;
    mask = (longint'(1) << w) - 1;
    if (sub) uns = a + ((~b) & mask) + 1;
    else     uns = a + b + cin;
    sum = uns & mask;
    c = ((uns >> w) & 1) != 0;
    n = ((sum >> (w - 1)) & 1) != 0;
    z = (sum == 0);
    sa = (a >= (longint'(1) << (w - 1))) ? a - (mask + 1) : a;
    sb = (b >= (longint'(1) << (w - 1))) ? b - (mask + 1) : b;
    exact = sub ? sa - sb : sa + sb + cin;
    v = (exact > (mask >> 1)) || (exact < -((mask >> 1) + 1));
  endtask

  task automatic check8(input string tag);
    longint es; bit en, ez, ec, ev;
    expect_vals(8, a8, b8, sub8, cin8, es, en, ez, ec, ev);
    check({tag, " sum R1/R2"}, s8, es);
    check({tag, " R3 neg"}, n8, en);
    check({tag, " R4 zero"}, z8, ez);
    check({tag, " R5 carry"}, c8, ec);
    check({tag, " R6 ovf"}, v8, ev);
  endtask

  task automatic check16(input string tag);
    longint es; bit en, ez, ec, ev;
    expect_vals(16, a16, b16, sub16, cin16, es, en, ez, ec, ev);
    check({tag, " sum R1/R2/R7"}, s16, es);
    check({tag, " R3 neg"}, n16, en);
    check({tag, " R4 zero"}, z16, ez);
    check({tag, " R5 carry"}, c16, ec);
    check({tag, " R6 ovf"}, v16, ev);
  endtask

  initial begin
    logic [15:0] corners [8];
    longint keepSum; bit keepC, keepV;
    corners = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                16'hFFFF, 16'h5555, 16'hAAAA, 16'h0FF0};
    a8 = '0; b8 = '0; sub8 = 0; cin8 = 0;
    a16 = '0; b16 = '0; sub16 = 0; cin16 = 0;
    @(negedge clk);
    // idle state: zero inputs
    check("R4 idle zero flag", z16, 1);
    check("R1 idle sum", s16, 0);

    // R8: exhaustive sweep of the 8-bit build, all modes
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < 256; i++) begin
        for (int j = 0; j < 256; j++) begin
          a8 = 8'(i); b8 = 8'(j); sub8 = m[1]; cin8 = m[0];
          #1;
          check8("R8 sweep");
          #1;
        end
      end
    end

    // R7: carry crossing every slice boundary
    a16 = 16'hFFFF; b16 = 16'h0000; sub16 = 0; cin16 = 1; #1;
    check("R7 full-width ripple sum", s16, 0);
    check("R7 full-width ripple carry", c16, 1);
    check16("R7 ripple");
    a16 = 16'h0FFF; b16 = 16'h0001; cin16 = 0; #1;
    check("R7 carry into top slice", s16, 16'h1000);

    // R6 corners: max positive + 1, most negative - 1
    a16 = 16'h7FFF; b16 = 16'h0001; sub16 = 0; cin16 = 0; #1;
    check("R6 max pos plus one", v16, 1);
    a16 = 16'h8000; b16 = 16'h0001; sub16 = 1; #1;
    check("R6 most neg minus one", v16, 1);
    a16 = 16'h0000; b16 = 16'h8000; sub16 = 1; #1;
    check("R6 zero minus most neg", v16, 1);
    a16 = 16'h0005; b16 = 16'h0005; sub16 = 1; #1;
    check("R5 equal subtract no borrow", c16, 1);
    check("R4 equal subtract zero", z16, 1);
    a16 = 16'h0004; b16 = 16'h0005; #1;
    check("R5 borrow clears carry", c16, 0);

    // R2: carryIn ignored while subtracting
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        a16 = corners[i]; b16 = corners[j]; sub16 = 1; cin16 = 0; #1;
        keepSum = s16; keepC = c16; keepV = v16;
        cin16 = 1; #1;
        check("R2 cin ignored sum", s16, keepSum);
        check("R2 cin ignored carry", c16, keepC);
        check("R2 cin ignored ovf", v16, keepV);
      end
    end

    // corner cross-product, all modes, 16 bits
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          a16 = corners[i]; b16 = corners[j]; sub16 = m[1]; cin16 = m[0]; #1;
          check16("corner");
        end
      end
    end

    // random 16-bit operands
    for (int r = 0; r < 3000; r++) begin
      a16 = 16'($urandom); b16 = 16'($urandom);
      sub16 = 1'($urandom); cin16 = 1'($urandom); #1;
      check16("random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule